// File: doc/BRIEF.md
# Hall Sensor Half-Period Speed Meter

This block measures how fast a rotor turns by timing the three commutation sensor lines of a brushless motor. Each line is synchronised to the local clock and every level change, rising or falling, closes one half-cycle measurement. A per-line counter advances once per clock. At each change, the finished half-cycle is kept and the half-cycle before it is also retained. The two are added to give a full signal period. Because one high phase and one low phase always make up the sum, an unequal duty cycle caused by a tilted or offset sensor does not distort the result. The three lines are one third of a period apart, so together they give six fresh period values per electrical cycle.

A line that stays quiet until its counter saturates reports zero speed. A separate watchdog observes all three lines together and raises a sticky stall fault when none of them changes for a programmed number of cycles. That fault covers a locked rotor or a broken sensor harness. It does not depend on the speed measurement, so it still works at the very low speeds seen during start-up. The surrounding control uses the fault to block the inverter gate pulses.

Top module: `hall_speed_meter`

## Requirements
- R1: After reset, all three period outputs are 0, all three zero-speed bits are 1, the valid strobes are 0 and the stall fault is 0.
- R2: Each level change of a line, rising or falling, ends a half-cycle. The half-cycle length is the number of clock cycles between two successive detected changes of that line.
- R3: A line's period output equals the sum of its two most recent half-cycle lengths. With an unequal duty cycle such as 30/70 cycles, the output is still the full period of 100.
- R4: Valid strobe bit i (0 = line A, 1 = line B, 2 = line C) pulses for exactly one cycle per accepted change on line i. It does so only when both summed half-cycles are below CNT_MAX.
- R5: The half-cycle counter saturates at CNT_MAX and never wraps. A half-cycle of CNT_MAX-1 cycles still produces a valid period. A half-cycle of CNT_MAX cycles or more produces no strobe.
- R6: When a line's counter reaches CNT_MAX without a change, that line's zero-speed bit goes to 1 and its period output reads 0. The bit returns to 0 only after two complete half-cycles below CNT_MAX have been measured.
- R7: The three lines are measured independently. Activity on one line changes neither the strobes nor the zero-speed bits of another line.
- R8: The stall fault rises when STALL_LIMIT consecutive cycles pass with no detected change on any line. It does not rise earlier.
- R9: Once raised, the stall fault stays at 1 whatever the lines do, until the next reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Measurement clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| hall_a | input | 1 | Sensor line A, asynchronous |
| hall_b | input | 1 | Sensor line B, asynchronous |
| hall_c | input | 1 | Sensor line C, asynchronous |
| period_a | output | CNT_W+1 | Full period of line A in clock cycles, 0 at zero speed |
| period_b | output | CNT_W+1 | Full period of line B in clock cycles, 0 at zero speed |
| period_c | output | CNT_W+1 | Full period of line C in clock cycles, 0 at zero speed |
| period_vld | output | 3 | One-cycle update strobe per line, bit 0 = A |
| zero_spd | output | 3 | Zero-speed indication per line, bit 0 = A |
| stall_fault | output | 1 | Sticky fault: no line changed for STALL_LIMIT cycles |

## Verification
The bench drives unequal half-cycles. A design that reported only the latest half, or doubled it, would then give a period that wanders from one change to the next instead of a constant one. Half-cycles of CNT_MAX-1 and CNT_MAX are tested at the saturation boundary. There an off-by-one comparison either drops a legal strobe or accepts a saturated one, and a wrapping counter would produce a small, false period. The bench also restarts a line after zero speed and counts how many changes pass before the strobe returns. The stall fault is sampled just before and just after its limit and again after the lines resume. This exposes a detector that fires early, fires late, or forgets the fault.

// File: rtl/hall_speed_pkg.sv
package hall_speed_pkg;
  localparam int NUM_LINES = 3;

  function automatic int unsigned bits_for(input int unsigned value);
    return (value < 2) ? 1 : $clog2(value + 1);
  endfunction
endpackage

// File: rtl/hall_edge_sync.sv
module hall_edge_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hall_in,
  output logic level_o,
  output logic edge_o
);
  logic [SYNC_STAGES-1:0] sync_q, sync_d;
  logic                   prev_q, prev_d;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_comb sync_d = hall_in;
    end else begin : g_many
      always_comb sync_d = {sync_q[SYNC_STAGES-2:0], hall_in};
    end
  endgenerate

  always_comb prev_d = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      prev_q <= prev_d;
    end
  end

  assign level_o = sync_q[SYNC_STAGES-1];
  assign edge_o  = sync_q[SYNC_STAGES-1] ^ prev_q;

  // R2
  edge_is_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    edge_o |=> (prev_q == $past(level_o)));
endmodule

// File: rtl/half_period_timer.sv
module half_period_timer #(
  parameter int CNT_W   = 16,
  parameter int CNT_MAX = 50000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             edge_i,
  output logic [CNT_W:0]   period_o,
  output logic             vld_o,
  output logic             zero_o
);
  localparam logic [CNT_W-1:0] SAT = CNT_W'(CNT_MAX);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] cur_q, cur_d;
  logic [CNT_W-1:0] prev_q, prev_d;
  logic             vld_q, vld_d;

  always_comb begin
    cnt_d  = cnt_q;
    cur_d  = cur_q;
    prev_d = prev_q;
    vld_d  = 1'b0;
    if (edge_i) begin
      prev_d = cur_q;
      cur_d  = cnt_q;
      cnt_d  = ONE;
      vld_d  = (cnt_q != SAT) && (cur_q != SAT);
    end else if (cnt_q != SAT) begin
      cnt_d  = cnt_q + ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= SAT;
      cur_q  <= SAT;
      prev_q <= SAT;
      vld_q  <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      cur_q  <= cur_d;
      prev_q <= prev_d;
      vld_q  <= vld_d;
    end
  end

  assign zero_o   = (cnt_q == SAT) || (cur_q == SAT) || (prev_q == SAT);
  assign vld_o    = vld_q;
  assign period_o = zero_o ? '0 : ({1'b0, cur_q} + {1'b0, prev_q});

  // R5
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != '0) && (cnt_q <= SAT));
  // R5
  sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == SAT && !edge_i) |=> (cnt_q == SAT));
  // R2
  cnt_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    edge_i |=> (cnt_q == ONE));
  // R4
  vld_fresh_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vld_o |-> (!zero_o && period_o != '0));
  // R4
  vld_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vld_o |=> !vld_o);
endmodule

// File: rtl/stall_watch.sv
module stall_watch #(
  parameter int STALL_LIMIT = 200000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic any_edge_i,
  output logic fault_o
);
  localparam int SW = hall_speed_pkg::bits_for(STALL_LIMIT);
  localparam logic [SW-1:0] LAST = SW'(STALL_LIMIT - 1);

  logic [SW-1:0] quiet_q, quiet_d;
  logic          fault_q, fault_d;

  always_comb begin
    quiet_d = quiet_q;
    fault_d = fault_q;
    if (any_edge_i) begin
      quiet_d = '0;
    end else begin
      if (quiet_q == LAST) fault_d = 1'b1;
      else                 quiet_d = quiet_q + SW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      quiet_q <= '0;
      fault_q <= 1'b0;
    end else begin
      quiet_q <= quiet_d;
      fault_q <= fault_d;
    end
  end

  assign fault_o = fault_q;

  // R9
  fault_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault_o |=> fault_o);
  // R8
  fault_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fault_o) |-> ($past(quiet_q) == LAST && !$past(any_edge_i)));
endmodule

// File: rtl/hall_speed_meter.sv
module hall_speed_meter #(
  parameter int CNT_W       = 16,
  parameter int CNT_MAX     = 50000,
  parameter int STALL_LIMIT = 200000,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hall_a,
  input  logic             hall_b,
  input  logic             hall_c,
  output logic [CNT_W:0]   period_a,
  output logic [CNT_W:0]   period_b,
  output logic [CNT_W:0]   period_c,
  output logic [2:0]       period_vld,
  output logic [2:0]       zero_spd,
  output logic             stall_fault
);
  import hall_speed_pkg::*;

  logic [1:0] rst_pipe_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_int_n = rst_pipe_q[1];

  logic [NUM_LINES-1:0] hall_vec;
  logic [NUM_LINES-1:0] level_vec;
  logic [NUM_LINES-1:0] edge_vec;
  logic [CNT_W:0]       per_arr [NUM_LINES];

  assign hall_vec = {hall_c, hall_b, hall_a};

  for (genvar ln = 0; ln < NUM_LINES; ln++) begin : g_line
    hall_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst_n   (rst_int_n),
      .hall_in (hall_vec[ln]),
      .level_o (level_vec[ln]),
      .edge_o  (edge_vec[ln])
    );
    half_period_timer #(.CNT_W(CNT_W), .CNT_MAX(CNT_MAX)) u_timer (
      .clk      (clk),
      .rst_n    (rst_int_n),
      .edge_i   (edge_vec[ln]),
      .period_o (per_arr[ln]),
      .vld_o    (period_vld[ln]),
      .zero_o   (zero_spd[ln])
    );
  end

  stall_watch #(.STALL_LIMIT(STALL_LIMIT)) u_stall (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .any_edge_i (|edge_vec),
    .fault_o    (stall_fault)
  );

  assign period_a = per_arr[0];
  assign period_b = per_arr[1];
  assign period_c = per_arr[2];

  // R7
  line_isolation_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (edge_vec == 3'b001) |=> (period_vld[2:1] == 2'b00));
endmodule

// File: tb/tb_hall_speed_meter.sv
module tb_hall_speed_meter;
  localparam int CNT_W   = 10;
  localparam int CMAX    = 200;
  localparam int SLIM    = 400;
  localparam int PW      = CNT_W + 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] hall_v = 3'b000;
  logic [PW-1:0] period_a, period_b, period_c;
  logic [2:0] period_vld, zero_spd;
  logic stall_fault;

  always #2.5 clk = ~clk;

  hall_speed_meter #(.CNT_W(CNT_W), .CNT_MAX(CMAX), .STALL_LIMIT(SLIM),
                     .SYNC_STAGES(2)) dut (
    .clk(clk), .rst_n(rst_n),
    .hall_a(hall_v[0]), .hall_b(hall_v[1]), .hall_c(hall_v[2]),
    .period_a(period_a), .period_b(period_b), .period_c(period_c),
    .period_vld(period_vld), .zero_spd(zero_spd), .stall_fault(stall_fault)
  );

  typedef struct { int line; int value; string req; } exp_t;
  exp_t sb_q[$];

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  int last_t[3];
  int m_cur[3];
  bit seen[3];
  bit mon_on = 1'b0;
  bit done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 3; i++) begin
      seen[i] = 1'b0; m_cur[i] = CMAX; last_t[i] = 0;
    end
  endtask

  task automatic toggle(input int ln, input string req);
    int n;
    exp_t e;
    n = seen[ln] ? (cyc - last_t[ln]) : CMAX;
    if (n > CMAX) n = CMAX;
    if (n < CMAX && m_cur[ln] < CMAX) begin
      e.line = ln; e.value = n + m_cur[ln]; e.req = req;
      sb_q.push_back(e);
    end
    m_cur[ln] = n;
    seen[ln] = 1'b1;
    last_t[ln] = cyc;
    hall_v[ln] = ~hall_v[ln];
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic int per_of(input int ln);
    case (ln)
      0: return int'(period_a);
      1: return int'(period_b);
      default: return int'(period_c);
    endcase
  endfunction

  // monitor: pop and compare on each strobe
  always @(negedge clk) begin
    if (mon_on) begin
      for (int i = 0; i < 3; i++) begin
        if (period_vld[i]) begin
          if (sb_q.size() == 0) begin
            chk(1'b0, "R4", $sformatf("unexpected strobe line %0d", i), per_of(i), 0);
          end else begin
            exp_t e;
            e = sb_q.pop_front();
            chk(e.line == i, e.req, "strobe line", i, e.line);
            chk(per_of(i) == e.value, e.req, "period value", per_of(i), e.value);
          end
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    model_reset();
    idle(4);
    rst_n = 1'b1;
    idle(4);
    // R1 reset state
    chk(period_a == 0 && period_b == 0 && period_c == 0, "R1", "periods",
        int'(period_a) + int'(period_b) + int'(period_c), 0);
    chk(zero_spd == 3'b111, "R1", "zero_spd", int'(zero_spd), 7);
    chk(period_vld == 3'b000, "R1", "period_vld", int'(period_vld), 0);
    chk(stall_fault == 1'b0, "R1", "stall_fault", int'(stall_fault), 0);
    mon_on = 1'b1;

    // R2 equal half-cycles on line A
    for (int k = 0; k < 6; k++) begin toggle(0, "R2"); idle(50); end

    // R3 unequal duty on line B, period stays 100
    for (int k = 0; k < 8; k++) begin toggle(1, "R3"); idle((k % 2 == 0) ? 30 : 70); end

    // R7 interleaved lines A and C at different rates
    for (int t = 0; t < 480; t++) begin
      if (t % 40 == 0) toggle(0, "R7");
      if (t % 60 == 21) toggle(2, "R7");
      idle(1);
    end
    chk(zero_spd[1] == 1'b1, "R7", "idle line B zero bit", int'(zero_spd[1]), 1);
    chk(zero_spd[0] == 1'b0, "R7", "active line A zero bit", int'(zero_spd[0]), 0);
    chk(zero_spd[2] == 1'b0, "R7", "active line C zero bit", int'(zero_spd[2]), 0);

    // R5 saturation boundary on line A
    toggle(0, "R5"); idle(CMAX - 1);
    toggle(0, "R5"); idle(CMAX - 1);
    toggle(0, "R5"); idle(CMAX);
    toggle(0, "R5"); idle(5);
    chk(zero_spd[0] == 1'b1, "R5", "saturated half gives zero bit", int'(zero_spd[0]), 1);

    // R6 zero speed then restart
    idle(CMAX + 20);
    chk(zero_spd[0] == 1'b1, "R6", "zero bit after timeout", int'(zero_spd[0]), 1);
    chk(period_a == 0, "R6", "period at zero speed", int'(period_a), 0);
    toggle(0, "R6"); idle(50);
    chk(zero_spd[0] == 1'b1, "R6", "zero bit after first change", int'(zero_spd[0]), 1);
    toggle(0, "R6"); idle(50);
    chk(zero_spd[0] == 1'b1, "R6", "zero bit after second change", int'(zero_spd[0]), 1);
    toggle(0, "R6"); idle(5);
    chk(zero_spd[0] == 1'b0, "R6", "zero bit after two fresh halves", int'(zero_spd[0]), 0);
    chk(period_a == 100, "R6", "period after restart", int'(period_a), 100);

    // R8 stall detection window, measured from the last change
    idle(SLIM - 15);
    chk(stall_fault == 1'b0, "R8", "fault before limit", int'(stall_fault), 0);
    idle(20);
    chk(stall_fault == 1'b1, "R8", "fault after limit", int'(stall_fault), 1);

    // R9 sticky despite renewed activity
    for (int k = 0; k < 4; k++) begin toggle(k % 3, "R9"); idle(30); end
    chk(stall_fault == 1'b1, "R9", "fault held with activity", int'(stall_fault), 1);
    idle(10);
    chk(sb_q.size() == 0, "R4", "missing strobes", sb_q.size(), 0);

    mon_on = 1'b0;
    rst_n = 1'b0;
    idle(3);
    rst_n = 1'b1;
    idle(3);
    chk(stall_fault == 1'b0, "R9", "fault cleared by reset", int'(stall_fault), 0);
    chk(zero_spd == 3'b111, "R1", "zero_spd after second reset", int'(zero_spd), 7);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule